// File: doc/BRIEF.md
# Two-channel sample delay with cycle-windowed register access

The block gives a host two access registers: a write register that collects one new sample per channel in each sample period, and a read register that hands back the sample of the same channel from a programmable number of periods earlier. A cycle counter runs from 0 up to a programmable last-cycle value `Ni` and then wraps, so each period is `Ni`+1 clocks long. A sync strobe forces the counter back to cycle 0. The cycle at which a write lands decides which channel it belongs to. Within a window only the last write counts. A few guard cycles accept no access at all.

The block has two word modes. In the 32-bit mode the CH1 write window is cycles 0 to 66 and cycle 67 is a guard. In the 30-bit mode the CH1 window is 0 to 62, the guard is cycle 63, and only 30 data bits are kept. At the last cycle of every period, each channel's captured value moves into an eight-stage delay line. Reads pick the stage that the delay length selects. A refused access raises a one-cycle violation flag, and the read result is left untouched.

Top module: `dly2ch_reg`

## Requirements
- R1: The cycle counter is 0 in the clock after `sync_i` is high. Otherwise it counts up by one per clock and goes back to 0 in the clock after it reaches `ni_i`.
- R2: A write is taken as the CH1 sample when it falls in cycles 0..66 in 32-bit mode (`mode30_i`=0), or in cycles 0..62 in 30-bit mode (`mode30_i`=1). A later accepted CH1 write in the same period replaces an earlier one.
- R3: A write is taken as the CH2 sample when it falls in cycles 68..`Ni`-2 in 32-bit mode, or in cycles 64..`Ni`-2 in 30-bit mode. The last such write in a period wins.
- R4: A write in cycle 67 (32-bit mode), in cycle 63 (30-bit mode), or in cycle `Ni`-1 or `Ni` (either mode) is refused. Neither captured sample changes, and `viol_o` is 1 in the next clock.
- R5: A read with `rd_ch_i`=0 (CH1) is accepted in cycles 0..65 and 134..`Ni`-2 in 32-bit mode, and in cycles 0..61 and 126..`Ni`-2 in 30-bit mode. At any other cycle it is refused: `viol_o` is 1 in the next clock, `rd_valid_o` is 0, and `rd_data_o` keeps its value.
- R6: A read with `rd_ch_i`=1 (CH2) is accepted only in cycles 62..125. At any other cycle it is refused in the way R5 describes.
- R7: At cycle `Ni`, each channel's captured sample is pushed into its delay line. An accepted read returns, in the next clock on `rd_data_o`, the value pushed r periods earlier, where r = `dly_len_i`+1 (1..8).
- R8: `rd_valid_o` is 1 in the clock after an accepted read only when at least r pushes have happened since reset. It is 0 in every other clock.
- R9: In 30-bit mode a write stores only `wr_data_i[29:0]`, so bits 31:30 of that sample read back as 0.
- R10: When `ni_i` is below 135 in 32-bit mode, or below 127 in 30-bit mode, every write and every read is refused and flagged as in R4 and R5.
- R11: After reset, `rd_data_o`, `rd_valid_o` and `viol_o` are 0, and every delay-line stage holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_i | input | 1 | Sample-period strobe; the counter restarts at cycle 0 |
| ni_i | input | 9 | Index of the last cycle in a period |
| mode30_i | input | 1 | 1 = 30-bit word mode, 0 = 32-bit word mode |
| dly_len_i | input | 3 | Delay length minus one (r = value + 1) |
| wr_en_i | input | 1 | Write strobe for the write register |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe for the read register |
| rd_ch_i | input | 1 | Read channel: 0 = CH1, 1 = CH2 |
| rd_data_o | output | 32 | Delayed sample returned by the last accepted read |
| rd_valid_o | output | 1 | One-clock flag: the last read was accepted and the line is filled to depth r |
| viol_o | output | 1 | One-clock flag: an access in the previous clock was refused |

## Verification
The assertions assume that the strobes and the channel select are clean binary levels. They also assume that a guard cycle can be found from the internal counter and the current `ni_i` and mode alone, which holds only if those two inputs do not change in the middle of a period while an access is in flight. The stimulus changes `ni_i`, the mode and the delay length only together with a sync pulse that carries no access. Random writes and reads then run for many whole periods under each setting. The settings include both mode minimums and a period that is too short.

// File: rtl/dly2ch_pkg.sv
package dly2ch_pkg;

  // Cycle landmarks for the two word modes.
  localparam int unsigned A_WR_LAST_32 = 66;
  localparam int unsigned WR_GAP_32    = 67;
  localparam int unsigned B_WR_FIRST_32 = 68;
  localparam int unsigned A_RD_EARLY_32 = 65;
  localparam int unsigned A_RD_LATE_32  = 134;
  localparam int unsigned MIN_NI_32     = 135;

  localparam int unsigned A_WR_LAST_30 = 62;
  localparam int unsigned WR_GAP_30    = 63;
  localparam int unsigned B_WR_FIRST_30 = 64;
  localparam int unsigned A_RD_EARLY_30 = 61;
  localparam int unsigned A_RD_LATE_30  = 126;
  localparam int unsigned MIN_NI_30     = 127;

  localparam int unsigned B_RD_FIRST = 62;
  localparam int unsigned B_RD_LAST  = 125;

  localparam int unsigned NUM_CH = 2;

  typedef struct packed {
    logic wr_a;
    logic wr_b;
    logic rd_a;
    logic rd_b;
  } win_t;

endpackage

// File: rtl/dly2ch_timer.sv
module dly2ch_timer
  import dly2ch_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] ni_i,
  input  logic             mode30_i,
  output logic [CNT_W-1:0] cyc_o,
  output win_t             win_o,
  output logic             push_o
);

  logic [CNT_W-1:0] cyc_q;
  logic [CNT_W-1:0] cyc_d;
  logic [CNT_W:0]   cyc_x;
  logic [CNT_W:0]   ni_x;
  logic             short_per;
  logic             before_tail;
  logic [CNT_W-1:0] a_wr_last;
  logic [CNT_W-1:0] b_wr_first;
  logic [CNT_W-1:0] a_rd_early;
  logic [CNT_W-1:0] a_rd_late;
  logic             at_end;

  always_comb begin
    cyc_x       = {1'b0, cyc_q};
    ni_x        = {1'b0, ni_i};
    at_end      = (cyc_q >= ni_i);
    before_tail = ((cyc_x + (CNT_W+1)'(2)) <= ni_x);
    short_per   = mode30_i ? (ni_i < CNT_W'(MIN_NI_30)) : (ni_i < CNT_W'(MIN_NI_32));
    a_wr_last   = mode30_i ? CNT_W'(A_WR_LAST_30)  : CNT_W'(A_WR_LAST_32);
    b_wr_first  = mode30_i ? CNT_W'(B_WR_FIRST_30) : CNT_W'(B_WR_FIRST_32);
    a_rd_early  = mode30_i ? CNT_W'(A_RD_EARLY_30) : CNT_W'(A_RD_EARLY_32);
    a_rd_late   = mode30_i ? CNT_W'(A_RD_LATE_30)  : CNT_W'(A_RD_LATE_32);

    win_o.wr_a = !short_per && (cyc_q <= a_wr_last);
    win_o.wr_b = !short_per && (cyc_q >= b_wr_first) && before_tail;
    win_o.rd_a = !short_per && ((cyc_q <= a_rd_early) ||
                                ((cyc_q >= a_rd_late) && before_tail));
    win_o.rd_b = !short_per && (cyc_q >= CNT_W'(B_RD_FIRST)) &&
                 (cyc_q <= CNT_W'(B_RD_LAST));

    if (sync_i || at_end) begin
      cyc_d = '0;
    end else begin
      cyc_d = cyc_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
    end else begin
      cyc_q <= cyc_d;
    end
  end

  assign cyc_o  = cyc_q;
  assign push_o = at_end;

endmodule

// File: rtl/dly2ch_cap.sv
module dly2ch_cap #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] val_q;
  logic [DATA_W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (we_i) begin
      val_d = din_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else begin
      val_q <= val_d;
    end
  end

  assign q_o = val_q;

endmodule

// File: rtl/dly2ch_line.sv
module dly2ch_line #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] dout_o
);

  localparam int LINE_W = DEPTH * DATA_W;

  logic [LINE_W-1:0] stg_q;
  logic [LINE_W-1:0] stg_d;
  logic [SEL_W-1:0]  sel_c;

  always_comb begin
    stg_d = stg_q;
    if (push_i) begin
      stg_d = {stg_q[LINE_W-DATA_W-1:0], din_i};
    end
    sel_c = sel_i;
    if (int'(sel_i) >= DEPTH) begin
      sel_c = SEL_W'(DEPTH - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign dout_o = stg_q[sel_c*DATA_W +: DATA_W];

endmodule

// File: rtl/dly2ch_reg.sv
module dly2ch_reg
  import dly2ch_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 30,
  parameter int CNT_W    = 9,
  parameter int DEPTH    = 8,
  localparam int SEL_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [CNT_W-1:0]  ni_i,
  input  logic              mode30_i,
  input  logic [SEL_W-1:0]  dly_len_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              rd_ch_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              viol_o
);

  localparam int PAD_W  = DATA_W - NARROW_W;
  localparam int FILL_W = SEL_W + 1;

  logic rst_m;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic [CNT_W-1:0] cyc;
  win_t             win;
  logic             push;

  dly2ch_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_q),
    .sync_i   (sync_i),
    .ni_i     (ni_i),
    .mode30_i (mode30_i),
    .cyc_o    (cyc),
    .win_o    (win),
    .push_o   (push)
  );

  logic [DATA_W-1:0] wr_fit;
  logic [NUM_CH-1:0] we;
  logic              wr_ok;
  logic              rd_ok;

  always_comb begin
    wr_fit = mode30_i ? {{PAD_W{1'b0}}, wr_data_i[NARROW_W-1:0]} : wr_data_i;
    we[0]  = wr_en_i && win.wr_a;
    we[1]  = wr_en_i && win.wr_b;
    wr_ok  = |we;
    rd_ok  = rd_en_i && (rd_ch_i ? win.rd_b : win.rd_a);
  end

  logic [DATA_W-1:0] cap_q [NUM_CH];
  logic [DATA_W-1:0] tap   [NUM_CH];

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
    dly2ch_cap #(.DATA_W(DATA_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_q),
      .we_i  (we[gc]),
      .din_i (wr_fit),
      .q_o   (cap_q[gc])
    );

    dly2ch_line #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_line (
      .clk    (clk),
      .rst_n  (rst_q),
      .push_i (push),
      .din_i  (cap_q[gc]),
      .sel_i  (dly_len_i),
      .dout_o (tap[gc])
    );
  end

  logic [FILL_W-1:0] fill_q;
  logic [FILL_W-1:0] fill_d;
  logic              primed;
  logic [DATA_W-1:0] rdat_q;
  logic [DATA_W-1:0] rdat_d;
  logic              rval_q;
  logic              rval_d;
  logic              viol_q;
  logic              viol_d;

  always_comb begin
    fill_d = fill_q;
    if (push && (fill_q != FILL_W'(DEPTH))) begin
      fill_d = fill_q + FILL_W'(1);
    end
    primed = (fill_q > {1'b0, dly_len_i});
    rdat_d = rdat_q;
    if (rd_ok) begin
      rdat_d = rd_ch_i ? tap[1] : tap[0];
    end
    rval_d = rd_ok && primed;
    viol_d = (wr_en_i && !wr_ok) || (rd_en_i && !rd_ok);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      fill_q <= '0;
      rdat_q <= '0;
      rval_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      fill_q <= fill_d;
      rdat_q <= rdat_d;
      rval_q <= rval_d;
      viol_q <= viol_d;
    end
  end

  assign rd_data_o  = rdat_q;
  assign rd_valid_o = rval_q;
  assign viol_o     = viol_q;

endmodule

// File: rtl/dly2ch_chk.sv
module dly2ch_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_i,
  input logic [CNT_W-1:0]  ni_i,
  input logic              mode30_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              rd_ch_i,
  input logic [CNT_W-1:0]  cyc,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_valid_o,
  input logic              viol_o
);

  logic in_tail;
  logic short_per;

  assign in_tail   = (({1'b0, cyc} + (CNT_W+1)'(1)) >= {1'b0, ni_i});
  assign short_per = mode30_i ? (ni_i < CNT_W'(127)) : (ni_i < CNT_W'(135));

  p_sync_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (cyc == '0));

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= ni_i) |=> (cyc == '0));

  p_tail_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && in_tail) |=> viol_o);

  p_gap_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (cyc == (mode30_i ? CNT_W'(63) : CNT_W'(67)))) |=> viol_o);

  p_tail_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && in_tail) |=> (viol_o && !rd_valid_o && $stable(rd_data_o)));

  p_ch2_early_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_ch_i && (cyc < CNT_W'(62))) |=> (viol_o && $stable(rd_data_o)));

  p_valid_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_en_i));

  p_short_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (short_per && (wr_en_i || rd_en_i)) |=> viol_o);

endmodule

bind dly2ch_reg dly2ch_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .sync_i     (sync_i),
  .ni_i       (ni_i),
  .mode30_i   (mode30_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .rd_ch_i    (rd_ch_i),
  .cyc        (cyc),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .viol_o     (viol_o)
);

// File: tb/dly2ch_reg_tb.sv
`timescale 1ns/1ps
module dly2ch_reg_tb;

  logic        clk;
  logic        rst_n;
  logic        sync_i;
  logic [8:0]  ni_i;
  logic        mode30_i;
  logic [2:0]  dly_len_i;
  logic        wr_en_i;
  logic [31:0] wr_data_i;
  logic        rd_en_i;
  logic        rd_ch_i;
  logic [31:0] rd_data_o;
  logic        rd_valid_o;
  logic        viol_o;

  dly2ch_reg u_dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .ni_i(ni_i), .mode30_i(mode30_i),
    .dly_len_i(dly_len_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_ch_i(rd_ch_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .viol_o(viol_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // Reference state built from the requirements.
  logic        run = 1'b0;
  int          m_cyc = 0;
  int          m_fill = 0;
  logic [31:0] m_cap1 = '0;
  logic [31:0] m_cap2 = '0;
  logic [31:0] m_sr1 [8];
  logic [31:0] m_sr2 [8];
  logic        m_pend = 1'b0;
  logic        e_viol = 1'b0;
  logic        e_valid = 1'b0;
  logic [31:0] e_data = '0;
  string       t_viol = "R4";
  string       t_data = "R7";

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle after %0d)", tag, act, exp, m_cyc);
    end
  endtask

  task automatic model_step();
    bit sh, a_wr, b_wr, a_rd, b_rd, wok, rok, tail_ok;
    int r;
    logic [31:0] fit;
    sh      = mode30_i ? (ni_i < 127) : (ni_i < 135);
    tail_ok = (m_cyc + 2) <= int'(ni_i);
    a_wr = !sh && (m_cyc <= (mode30_i ? 62 : 66));
    b_wr = !sh && (m_cyc >= (mode30_i ? 64 : 68)) && tail_ok;
    a_rd = !sh && ((m_cyc <= (mode30_i ? 61 : 65)) ||
                   ((m_cyc >= (mode30_i ? 126 : 134)) && tail_ok));
    b_rd = !sh && (m_cyc >= 62) && (m_cyc <= 125);
    wok  = wr_en_i && (a_wr || b_wr);
    rok  = rd_en_i && (rd_ch_i ? b_rd : a_rd);
    r    = int'(dly_len_i);
    m_pend = wr_en_i || rd_en_i;
    e_viol = (wr_en_i && !wok) || (rd_en_i && !rok);
    e_valid = rok && (m_fill > r);
    if (rok) e_data = rd_ch_i ? m_sr2[r] : m_sr1[r];
    if (sh) t_viol = "R10";
    else if (wr_en_i && !wok) t_viol = "R4";
    else if (rd_en_i && !rok) t_viol = rd_ch_i ? "R6" : "R5";
    else if (wok) t_viol = a_wr ? "R2" : "R3";
    else t_viol = rd_ch_i ? "R6" : "R5";
    if (!rok) t_data = rd_ch_i ? "R6" : "R5";
    else if (m_fill <= r) t_data = "R11";
    else if (mode30_i) t_data = "R9";
    else t_data = "R7";
    fit = mode30_i ? {2'b00, wr_data_i[29:0]} : wr_data_i;
    if (wok) begin
      if (a_wr) m_cap1 = fit;
      else m_cap2 = fit;
    end
    if (m_cyc >= int'(ni_i)) begin
      for (int i = 7; i > 0; i--) begin
        m_sr1[i] = m_sr1[i-1];
        m_sr2[i] = m_sr2[i-1];
      end
      m_sr1[0] = m_cap1;
      m_sr2[0] = m_cap2;
      if (m_fill < 8) m_fill++;
    end
    if (sync_i || (m_cyc >= int'(ni_i))) m_cyc = 0;
    else m_cyc++;
  endtask

  task automatic tick();
    @(posedge clk);
    if (run) model_step();
    @(negedge clk);
    if (run && m_pend) begin
      check(t_viol, {31'd0, viol_o}, {31'd0, e_viol});
      check("R8", {31'd0, rd_valid_o}, {31'd0, e_valid});
      check(t_data, rd_data_o, e_data);
    end
  endtask

  task automatic idle();
    sync_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0;
  endtask

  task automatic goto(input int c);
    idle();
    while (m_cyc != c) tick();
  endtask

  task automatic do_wr(input logic [31:0] d);
    wr_en_i = 1'b1; wr_data_i = d; tick(); wr_en_i = 1'b0;
  endtask

  task automatic do_rd(input logic ch);
    rd_en_i = 1'b1; rd_ch_i = ch; tick(); rd_en_i = 1'b0;
  endtask

  task automatic cfg(input logic m30, input int ni, input logic [2:0] dl);
    idle();
    mode30_i = m30; ni_i = 9'(ni); dly_len_i = dl;
    sync_i = 1'b1; tick(); sync_i = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(20 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    for (int i = 0; i < 8; i++) begin m_sr1[i] = '0; m_sr2[i] = '0; end
    rst_n = 1'b0; idle(); rd_ch_i = 1'b0; wr_data_i = '0;
    mode30_i = 1'b0; ni_i = 9'd150; dly_len_i = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state at the outputs
    check("R11", rd_data_o, 32'd0);
    check("R11", {31'd0, rd_valid_o}, 32'd0);
    check("R11", {31'd0, viol_o}, 32'd0);

    run = 1'b1;
    cfg(1'b0, 150, 3'd0);
    // R8: read before any push is accepted but not valid; R11: line holds zero
    goto(10); do_rd(1'b0);
    check("R8", {31'd0, rd_valid_o}, 32'd0);
    check("R11", rd_data_o, 32'd0);

    // R1: sync in mid period restarts the count
    goto(100);
    sync_i = 1'b1; tick(); sync_i = 1'b0;
    repeat (67) tick();
    do_wr(32'h1111_2222);
    check("R1", {31'd0, viol_o}, 32'd1);
    do_wr(32'h3333_4444);
    check("R1", {31'd0, viol_o}, 32'd0);

    // R2 / R3: last write in each window is kept
    goto(0);
    goto(5);  do_wr(32'hAAAA_0001);
    goto(10); do_wr(32'hBBBB_0002);
    goto(70); do_wr(32'hCCCC_0003);
    goto(100); do_wr(32'hDDDD_0004);
    goto(149); do_wr(32'hEEEE_0005);
    check("R4", {31'd0, viol_o}, 32'd1);
    goto(10); do_rd(1'b0);
    check("R2", rd_data_o, 32'hBBBB_0002);
    check("R8", {31'd0, rd_valid_o}, 32'd1);
    goto(80); do_rd(1'b1);
    check("R3", rd_data_o, 32'hDDDD_0004);
    goto(130); do_rd(1'b1);
    check("R6", rd_data_o, 32'hDDDD_0004);
    check("R6", {31'd0, viol_o}, 32'd1);

    // R9: 30-bit mode drops the top bits
    cfg(1'b1, 130, 3'd0);
    goto(3); do_wr(32'hFFFF_FFFF);
    goto(0); goto(5); do_rd(1'b0);
    check("R9", rd_data_o, 32'h3FFF_FFFF);

    // R10: period too short refuses accesses
    cfg(1'b0, 120, 3'd0);
    goto(10); do_wr(32'h5555_5555);
    check("R10", {31'd0, viol_o}, 32'd1);

    // Random phases over several settings
    for (int ph = 0; ph < 7; ph++) begin
      logic m30;
      int ni;
      case (ph)
        0: begin m30 = 1'b0; ni = 150; end
        1: begin m30 = 1'b1; ni = 130; end
        2: begin m30 = 1'b0; ni = 135; end
        3: begin m30 = 1'b1; ni = 127; end
        4: begin m30 = 1'b0; ni = 110; end
        5: begin m30 = 1'b1; ni = 160; end
        default: begin m30 = 1'b0; ni = 140; end
      endcase
      cfg(m30, ni, 3'($urandom % 8));
      for (int k = 0; k < 11 * (ni + 1); k++) begin
        wr_en_i   = (($urandom % 4) == 0);
        wr_data_i = $urandom;
        rd_en_i   = (($urandom % 3) == 0);
        rd_ch_i   = 1'($urandom % 2);
        tick();
      end
    end
    idle();
    tick();
    summary();
    $finish;
  end

endmodule